// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks, every cycle, one warp out of the group it owns and sends up to two of that warp's buffered instructions to three execution pipes: an arithmetic pipe (SP), a special-function pipe (SFU) and a memory pipe (MEM). A core holds `NUM_SCHED` copies of the block. Copy `SCHED_IDX` owns every warp whose ID, taken modulo `NUM_SCHED`, equals `SCHED_IDX`. The ports are indexed by supervised slot: slot `s` is warp `SCHED_IDX + s*NUM_SCHED`.

For each slot the caller shows the next `EXAM_N` buffer entries (default 2). Each entry has a presence flag, an instruction flag, a valid flag, an opcode class, a PC and a scoreboard hazard flag. The caller also gives the warp's waiting flag and the PC at the top of its reconvergence stack. Each pipe reports whether its input register is empty. The decision is combinational. The only state is the last-issued slot pointer. The block answers with per-pipe issue strobes and the issuing warp ID, per-slot flush requests with the redirect PC, and per-slot counts of how far each buffer steps.

Opcode class encoding on `ib_cls`: 0 = SP only, 1 = SFU only, 2 = may use SP or SFU, 3 = memory (load, store or barrier).

Top module: `warp_issue_sched`

## Requirements
- R1: `iss_wid` is the warp ID `SCHED_IDX + s*NUM_SCHED` of the slot `s` that issued. It is 0 when nothing issues, so every issued ID is congruent to `SCHED_IDX` modulo `NUM_SCHED`.
- R2: The search visits slots starting at the one after the last-issued slot and wraps round. It stops at the first slot that issues, and that slot becomes the new last-issued slot. After reset the pointer is 0, so slot 1 is searched first.
- R3: At most one instruction enters each pipe per cycle. All instructions issued in a cycle come from the same warp.
- R4: A warp whose waiting flag is set is not stepped, not flushed and does not issue.
- R5: An entry whose instruction PC differs from the warp's stack-top PC raises `fl_req` with `fl_pc` equal to the stack-top PC. That entry does not issue, and no further entry of that warp is examined in the cycle.
- R6: An entry with the valid flag set but no instruction also raises `fl_req` with the stack-top PC and ends the warp's examination.
- R7: An entry with its hazard flag set does not issue. It is still stepped.
- R8: A class-3 entry issues only to MEM, and only when `mem_empty` is 1.
- R9: A class-0 or class-2 entry goes to SP whenever SP is still free in that cycle.
- R10: A class-1 entry, or a class-2 entry that did not get SP, goes to SFU when SFU is still free. A class-1 entry never goes to SP.
- R11: Each examined entry adds one to `ib_step` of its slot, whether it issued or not. Examination continues while the warp is not waiting, the next entry is present and no flush has occurred, up to `EXAM_N` entries. Slots visited after the issuing slot are left untouched.
- R12: A pipe taken by an earlier entry of the warp is unavailable to a later entry in the same cycle. A strobe rises only for a pipe whose empty flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_wait | input | SUP | Per-slot warp waiting flag |
| ib_have | input | SUP x EXAM_N | Buffer entry present |
| ib_inst | input | SUP x EXAM_N | Entry holds an instruction |
| ib_vld | input | SUP x EXAM_N | Entry valid flag |
| ib_cls | input | SUP x EXAM_N x 2 | Opcode class |
| ib_pc | input | SUP x EXAM_N x PC_W | Entry instruction PC |
| sb_hz | input | SUP x EXAM_N | Scoreboard collision for the entry |
| rs_pc | input | SUP x PC_W | Reconvergence stack top PC |
| sp_empty | input | 1 | SP input register empty |
| sfu_empty | input | 1 | SFU input register empty |
| mem_empty | input | 1 | MEM input register empty |
| iss_sp | output | 1 | Issue strobe to SP |
| iss_sfu | output | 1 | Issue strobe to SFU |
| iss_mem | output | 1 | Issue strobe to MEM |
| iss_wid | output | WID_W | Warp ID of the issuing warp |
| fl_req | output | SUP | Flush and redirect request per slot |
| fl_pc | output | SUP x PC_W | Redirect PC per slot (0 when no flush) |
| ib_step | output | SUP x SW | Number of entries stepped per slot |

## Verification
The hardest state to reach from the ports is a cycle where several slots ahead of the winner flush or step without issuing, while the winner dual-issues and the rotation pointer has wrapped past the end. Random vectors bias hazards, blocked pipes and PC mismatches high enough that many slots fail in one cycle. The bench tracks its own copy of the pointer across cycles, so wrap-around order is compared on every vector. Directed vectors force each routing rule and each flush form on all slots at once.

// File: rtl/wis_pkg.sv
package wis_pkg;
   typedef enum logic [1:0] {
      OPC_ALU  = 2'd0,
      OPC_SFU  = 2'd1,
      OPC_DUAL = 2'd2,
      OPC_MEM  = 2'd3
   } opc_e;

   localparam int PIPE_SP  = 0;
   localparam int PIPE_SFU = 1;
   localparam int PIPE_MEM = 2;
   localparam int NPIPE    = 3;
endpackage

// File: rtl/wis_slot_eval.sv
module wis_slot_eval
   import wis_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int EXAM_N = 2,
   localparam int SW    = $clog2(EXAM_N + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wait_i,
   input  logic [EXAM_N-1:0]              have_i,
   input  logic [EXAM_N-1:0]              inst_i,
   input  logic [EXAM_N-1:0]              vld_i,
   input  logic [EXAM_N-1:0][1:0]         cls_i,
   input  logic [EXAM_N-1:0][PC_W-1:0]    pc_i,
   input  logic [EXAM_N-1:0]              hz_i,
   input  logic [PC_W-1:0]                stk_pc_i,
   input  logic [NPIPE-1:0]               free_i,
   output logic [NPIPE-1:0]               iss_o,
   output logic [SW-1:0]                  step_o,
   output logic                           flush_o
);

   logic             live_c;
   logic [NPIPE-1:0] free_c;
   opc_e             cls_c;
   logic             any_mem_c;

   always_comb begin
      iss_o   = '0;
      step_o  = '0;
      flush_o = 1'b0;
      live_c  = !wait_i;
      free_c  = free_i;
      cls_c   = OPC_ALU;
      for (int k = 0; k < EXAM_N; k++) begin
         if (live_c && have_i[k]) begin
            step_o = step_o + SW'(1);
            if (inst_i[k]) begin
               if (pc_i[k] != stk_pc_i) begin
                  flush_o = 1'b1;
                  live_c  = 1'b0;
               end else if (!hz_i[k]) begin
                  cls_c = opc_e'(cls_i[k]);
                  if (cls_c == OPC_MEM) begin
                     if (free_c[PIPE_MEM]) begin
                        iss_o[PIPE_MEM]  = 1'b1;
                        free_c[PIPE_MEM] = 1'b0;
                     end
                  end else if (free_c[PIPE_SP] && cls_c != OPC_SFU) begin
                     iss_o[PIPE_SP]  = 1'b1;
                     free_c[PIPE_SP] = 1'b0;
                  end else if (cls_c != OPC_ALU && free_c[PIPE_SFU]) begin
                     iss_o[PIPE_SFU]  = 1'b1;
                     free_c[PIPE_SFU] = 1'b0;
                  end
               end
            end else if (vld_i[k]) begin
               flush_o = 1'b1;
               live_c  = 1'b0;
            end
         end else begin
            live_c = 1'b0;
         end
      end
   end

   always_comb begin
      any_mem_c = 1'b0;
      for (int k = 0; k < EXAM_N; k++)
         if (cls_i[k] == OPC_MEM) any_mem_c = 1'b1;
   end

   p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wait_i |-> (step_o == '0 && iss_o == '0 && !flush_o));

   p_flush_stepped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> (step_o != '0));

   p_mem_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iss_o[PIPE_MEM] |-> (any_mem_c && free_i[PIPE_MEM]));

   p_issue_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(iss_o) <= int'(step_o)));

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
   parameter int N  = 8,
   localparam int PW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   output logic [PW-1:0] sel_o,
   output logic          any_o,
   output logic [N-1:0]  reach_o
);

   logic [PW-1:0] last_q;
   int            idx_c;

   always_comb begin
      any_o   = 1'b0;
      sel_o   = '0;
      reach_o = '0;
      idx_c   = 0;
      for (int i = 1; i <= N; i++) begin
         idx_c = int'(last_q) + i;
         if (idx_c >= N) idx_c = idx_c - N;
         if (!any_o) begin
            reach_o[idx_c] = 1'b1;
            if (req_i[idx_c]) begin
               any_o = 1'b1;
               sel_o = PW'(idx_c);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      last_q <= '0;
      else if (any_o)  last_q <= sel_o;
   end

   p_ptr_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |=> (last_q == $past(sel_o)));

   p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !any_o |=> $stable(last_q));

   p_winner_reached_r11: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (reach_o[sel_o] && req_i[sel_o]));

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import wis_pkg::*;
#(
   parameter int NUM_WARPS = 8,
   parameter int NUM_SCHED = 1,
   parameter int SCHED_IDX = 0,
   parameter int PC_W      = 32,
   parameter int EXAM_N    = 2,
   localparam int SUP      = (NUM_WARPS - SCHED_IDX + NUM_SCHED - 1) / NUM_SCHED,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int SW       = $clog2(EXAM_N + 1)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [SUP-1:0]                      wt_wait,
   input  logic [SUP-1:0][EXAM_N-1:0]          ib_have,
   input  logic [SUP-1:0][EXAM_N-1:0]          ib_inst,
   input  logic [SUP-1:0][EXAM_N-1:0]          ib_vld,
   input  logic [SUP-1:0][EXAM_N-1:0][1:0]     ib_cls,
   input  logic [SUP-1:0][EXAM_N-1:0][PC_W-1:0] ib_pc,
   input  logic [SUP-1:0][EXAM_N-1:0]          sb_hz,
   input  logic [SUP-1:0][PC_W-1:0]            rs_pc,
   input  logic                                sp_empty,
   input  logic                                sfu_empty,
   input  logic                                mem_empty,
   output logic                                iss_sp,
   output logic                                iss_sfu,
   output logic                                iss_mem,
   output logic [WID_W-1:0]                    iss_wid,
   output logic [SUP-1:0]                      fl_req,
   output logic [SUP-1:0][PC_W-1:0]            fl_pc,
   output logic [SUP-1:0][SW-1:0]              ib_step
);

   localparam int PW = (SUP > 1) ? $clog2(SUP) : 1;

   if (NUM_SCHED < 1) begin : g_chk_sched
      $error("warp_issue_sched: NUM_SCHED must be at least 1");
   end
   if (SCHED_IDX < 0 || SCHED_IDX >= NUM_SCHED || SCHED_IDX >= NUM_WARPS) begin : g_chk_idx
      $error("warp_issue_sched: SCHED_IDX out of range");
   end
   if (EXAM_N < 1) begin : g_chk_exam
      $error("warp_issue_sched: EXAM_N must be at least 1");
   end

   logic [NPIPE-1:0]          free_c;
   logic [SUP-1:0][NPIPE-1:0] slot_iss;
   logic [SUP-1:0][SW-1:0]    slot_step;
   logic [SUP-1:0]            slot_fl;
   logic [SUP-1:0]            slot_req;
   logic [SUP-1:0]            reach;
   logic [PW-1:0]             win;
   logic                      win_any;
   logic [NPIPE-1:0]          pick_iss;

   assign free_c = {mem_empty, sfu_empty, sp_empty};

   for (genvar s = 0; s < SUP; s++) begin : g_slot
      wis_slot_eval #(.PC_W(PC_W), .EXAM_N(EXAM_N)) u_eval (
         .clk      (clk),
         .rst_n    (rst_n),
         .wait_i   (wt_wait[s]),
         .have_i   (ib_have[s]),
         .inst_i   (ib_inst[s]),
         .vld_i    (ib_vld[s]),
         .cls_i    (ib_cls[s]),
         .pc_i     (ib_pc[s]),
         .hz_i     (sb_hz[s]),
         .stk_pc_i (rs_pc[s]),
         .free_i   (free_c),
         .iss_o    (slot_iss[s]),
         .step_o   (slot_step[s]),
         .flush_o  (slot_fl[s])
      );
      assign slot_req[s] = |slot_iss[s];
      assign fl_req[s]   = reach[s] & slot_fl[s];
      assign fl_pc[s]    = fl_req[s] ? rs_pc[s] : '0;
      assign ib_step[s]  = reach[s] ? slot_step[s] : '0;
   end

   wis_rr_pick #(.N(SUP)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (slot_req),
      .sel_o   (win),
      .any_o   (win_any),
      .reach_o (reach)
   );

   assign pick_iss = win_any ? slot_iss[win] : '0;
   assign iss_sp   = pick_iss[PIPE_SP];
   assign iss_sfu  = pick_iss[PIPE_SFU];
   assign iss_mem  = pick_iss[PIPE_MEM];
   assign iss_wid  = win_any ? WID_W'(SCHED_IDX + int'(win) * NUM_SCHED) : '0;

   p_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_sp || iss_sfu || iss_mem) |-> ((int'(iss_wid) % NUM_SCHED) == SCHED_IDX));

   p_pipe_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!iss_sp || sp_empty) && (!iss_sfu || sfu_empty) && (!iss_mem || mem_empty));

   p_wait_no_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wt_wait) == SUP |-> (fl_req == '0 && ib_step == '0 && !iss_sp && !iss_sfu && !iss_mem));

endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
   localparam int NW  = 8;
   localparam int NS  = 2;
   localparam int SI  = 1;
   localparam int PCW = 8;
   localparam int EX  = 2;
   localparam int SUP = (NW - SI + NS - 1) / NS;
   localparam int WW  = 3;
   localparam int SW  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [SUP-1:0]                 wt_wait;
   logic [SUP-1:0][EX-1:0]         ib_have, ib_inst, ib_vld, sb_hz;
   logic [SUP-1:0][EX-1:0][1:0]    ib_cls;
   logic [SUP-1:0][EX-1:0][PCW-1:0] ib_pc;
   logic [SUP-1:0][PCW-1:0]        rs_pc;
   logic sp_empty, sfu_empty, mem_empty;
   logic iss_sp, iss_sfu, iss_mem;
   logic [WW-1:0] iss_wid;
   logic [SUP-1:0] fl_req;
   logic [SUP-1:0][PCW-1:0] fl_pc;
   logic [SUP-1:0][SW-1:0] ib_step;

   warp_issue_sched #(.NUM_WARPS(NW), .NUM_SCHED(NS), .SCHED_IDX(SI), .PC_W(PCW), .EXAM_N(EX)) u0 (
      .clk(clk), .rst_n(rst_n), .wt_wait(wt_wait), .ib_have(ib_have), .ib_inst(ib_inst),
      .ib_vld(ib_vld), .ib_cls(ib_cls), .ib_pc(ib_pc), .sb_hz(sb_hz), .rs_pc(rs_pc),
      .sp_empty(sp_empty), .sfu_empty(sfu_empty), .mem_empty(mem_empty),
      .iss_sp(iss_sp), .iss_sfu(iss_sfu), .iss_mem(iss_mem), .iss_wid(iss_wid),
      .fl_req(fl_req), .fl_pc(fl_pc), .ib_step(ib_step));

   int n_chk = 0;
   int n_bad = 0;
   int m_last = 0;
   bit done = 1'b0;

   logic e_sp, e_sfu, e_mem;
   logic [WW-1:0] e_wid;
   logic [SUP-1:0] e_fl;
   logic [SUP-1:0][PCW-1:0] e_flpc;
   logic [SUP-1:0][SW-1:0] e_step;
   int e_next;

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // Reference: sequential walk in search order, pipes claimed as they go.
   task automatic model();
      bit spf, sff, mf;
      spf = sp_empty; sff = sfu_empty; mf = mem_empty;
      e_sp = 0; e_sfu = 0; e_mem = 0; e_wid = '0; e_fl = '0; e_flpc = '0; e_step = '0;
      e_next = m_last;
      for (int i = 1; i <= SUP; i++) begin
         int s;
         int cnt;
         bit stop;
         bit did;
         s = (m_last + i) % SUP; cnt = 0; stop = 0; did = 0;
         for (int k = 0; k < EX; k++) begin
            if (!stop && !wt_wait[s] && ib_have[s][k]) begin
               cnt++;
               if (ib_inst[s][k]) begin
                  if (ib_pc[s][k] != rs_pc[s]) begin
                     e_fl[s] = 1; e_flpc[s] = rs_pc[s]; stop = 1;
                  end else if (!sb_hz[s][k]) begin
                     if (ib_cls[s][k] == 2'd3) begin
                        if (mf) begin mf = 0; e_mem = 1; did = 1; end
                     end else if (spf && ib_cls[s][k] != 2'd1) begin
                        spf = 0; e_sp = 1; did = 1;
                     end else if ((ib_cls[s][k] == 2'd1 || ib_cls[s][k] == 2'd2) && sff) begin
                        sff = 0; e_sfu = 1; did = 1;
                     end
                  end
               end else if (ib_vld[s][k]) begin
                  e_fl[s] = 1; e_flpc[s] = rs_pc[s]; stop = 1;
               end
            end else stop = 1;
         end
         e_step[s] = SW'(cnt);
         if (did) begin
            e_wid = WW'(SI + s * NS);
            e_next = s;
            break;
         end
      end
   endtask

   task automatic apply(input string tag);
      #2;
      model();
      check({tag, " issue"}, 64'({iss_sp, iss_sfu, iss_mem, iss_wid}), 64'({e_sp, e_sfu, e_mem, e_wid}));
      check({tag, " flush"}, 64'({fl_req, fl_pc}), 64'({e_fl, e_flpc}));
      check({tag, " step"}, 64'(ib_step), 64'(e_step));
      m_last = e_next;
      @(negedge clk);
   endtask

   task automatic idle();
      wt_wait = '0; ib_have = '0; ib_inst = '0; ib_vld = '0; sb_hz = '0;
      ib_cls = '0; ib_pc = '0; rs_pc = '0;
      sp_empty = 1; sfu_empty = 1; mem_empty = 1;
   endtask

   task automatic put_all(input int k, input logic [1:0] cls);
      for (int s = 0; s < SUP; s++) begin
         rs_pc[s] = PCW'(8'h40 + s);
         ib_have[s][k] = 1; ib_inst[s][k] = 1; ib_vld[s][k] = 1;
         ib_cls[s][k] = cls; ib_pc[s][k] = rs_pc[s];
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: pointer resets to 0, so slot 1 (warp 3) wins first; R1 mapping
      put_all(0, 2'd0);
      #2;
      check("R2 first winner", 64'({iss_sp, iss_wid}), 64'({1'b1, 3'd3}));
      #(-0);
      apply("R2 after reset");

      // R3 R9 R10: two dual-capable entries -> SP then SFU from one warp
      idle(); put_all(0, 2'd2); put_all(1, 2'd2); apply("R3 R9 R10 dual issue");
      // R12: two SP-only entries, second blocked, both stepped
      idle(); put_all(0, 2'd0); put_all(1, 2'd0); apply("R12 same pipe");
      // R8: memory blocked, SP free -> no issue
      idle(); put_all(0, 2'd3); mem_empty = 0; apply("R8 mem blocked");
      idle(); put_all(0, 2'd3); put_all(1, 2'd3); apply("R8 mem once");
      // R10: SFU-only with SFU busy never goes to SP
      idle(); put_all(0, 2'd1); sfu_empty = 0; apply("R10 sfu busy");
      // R9: dual-capable with SP busy goes to SFU
      idle(); put_all(0, 2'd2); sp_empty = 0; apply("R9 sp busy");
      // R5: PC mismatch on all slots -> flush, redirect, one step
      idle(); put_all(0, 2'd0); put_all(1, 2'd0);
      for (int s = 0; s < SUP; s++) ib_pc[s][0] = rs_pc[s] ^ 8'h10;
      apply("R5 pc mismatch");
      // R6: valid without instruction
      idle(); put_all(0, 2'd0); put_all(1, 2'd0);
      for (int s = 0; s < SUP; s++) ib_inst[s][0] = 0;
      apply("R6 valid no inst");
      // R7 R11: hazards everywhere, every entry stepped
      idle(); put_all(0, 2'd0); put_all(1, 2'd2); sb_hz = '1; apply("R7 R11 hazard");
      // R4: waiting warps untouched
      idle(); put_all(0, 2'd0); put_all(1, 2'd0); wt_wait = '1; apply("R4 waiting");
      // R11: one slot fails ahead of the winner, later slots untouched
      idle(); put_all(0, 2'd1); sfu_empty = 0;
      ib_cls[(m_last + 2) % SUP][0] = 2'd0;
      apply("R11 partial search");

      // random mix
      for (int v = 0; v < 2000; v++) begin
         idle();
         for (int s = 0; s < SUP; s++) begin
            rs_pc[s] = PCW'($urandom);
            wt_wait[s] = ($urandom % 5) == 0;
            for (int k = 0; k < EX; k++) begin
               ib_have[s][k] = ($urandom % 4) != 0;
               ib_inst[s][k] = ($urandom % 8) != 0;
               ib_vld[s][k]  = $urandom % 2;
               ib_cls[s][k]  = 2'($urandom);
               ib_pc[s][k]   = (($urandom % 8) == 0) ? PCW'($urandom) : rs_pc[s];
               sb_hz[s][k]   = ($urandom % 3) == 0;
            end
         end
         sp_empty = ($urandom % 4) != 0;
         sfu_empty = ($urandom % 4) != 0;
         mem_empty = ($urandom % 4) != 0;
         apply("R2 R11 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule